// File: doc/BRIEF.md
# Multi-Mode Bidirectional Microcontroller Port

This block is one 8-bit bidirectional I/O port that a microcontroller programs through a small register bus. Each pin takes its output value from one of three sources: a software data register, a macrocell output of the programmable logic, or an address byte held by a transparent latch gated by the address-latch-enable strobe. Which byte of the 16-bit address is held is selectable. The output enable comes either from a software direction register or from an external product-term enable vector. Pins in the upper half can emulate open-drain drivers: such a pin pulls low for a 0 and releases for a 1.

Each pin also feeds an input cell. The cell captures the pin value for the internal logic bus, either as a gated transparent latch or as a register clocked by a capture clock. Software can read back the live pins, every register, the captured input value and the real driver state (enable-out). This lets firmware see whether the logic or its own settings currently own each pin.

Top module: `mio_port`

## Requirements
- R1: After an active-low reset every register is zero. All pins are tri-stated (`pad_oe` = 0), and reads at register addresses 1 to 7 return 0.
- R2: A write with `wr_en` high updates a register at the rising clock edge, selected by `reg_addr`: 0 = data register, 1 = direction, 2 = per-pin alternate-source enable, 3 = open-drain enable, 5 = configuration. Writes to addresses 4, 6 and 7 change nothing. Configuration bits: bit0 alternate kind (0 macrocell, 1 latched address), bit1 address byte (0 = A[7:0], 1 = A[15:8]), bit2 enable source (0 direction register, 1 product term), bit3 input cell mode (0 latch, 1 register).
- R3: A pin whose alternate-source bit is 0 outputs its data-register bit. When the bit is 1, the pin outputs the macrocell bit (configuration bit0 = 0) or the latched address bit (bit0 = 1).
- R4: With configuration bit2 = 0 each pin's enable is its direction bit. With bit2 = 1 it is the matching product-term enable bit.
- R5: The open-drain enable register stores only bits 7:4; bits 3:0 always read 0 and have no effect. An open-drain pin drives 0 with its enable set when its source is 0, and is released when its source is 1.
- R6: While `ale` is high the address latch follows the selected address byte. While `ale` is low it holds, even if the address or the byte select changes.
- R7: Reads are combinational on `rd_data`: 0 = live pin inputs, 1 = direction, 2 = alternate enable, 3 = open-drain enable, 4 = enable-out, 5 = configuration in bits 3:0 with zeros above, 6 = input cell value, 7 = data register.
- R8: The enable-out read (address 4) equals the real per-pin driver state `pad_oe`, including pins released by open-drain emulation.
- R9: In latch mode the input cell value follows `pad_in` while `in_gate` is high and holds while it is low.
- R10: In register mode the input cell value is the `pad_in` value sampled at the last rising edge of `in_cap_clk`. Gate activity has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational on `reg_addr` |
| mcell_in | input | 8 | Macrocell outputs from programmable logic |
| pt_oe_in | input | 8 | Product-term output enables |
| addr_in | input | 16 | Microcontroller address |
| ale | input | 1 | Address latch enable, latch transparent while high |
| pad_in | input | 8 | Pin input values |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin driver enables, 1 = driving |
| in_gate | input | 1 | Input cell gate for latch mode |
| in_cap_clk | input | 1 | Input cell capture clock for register mode |
| in_bus | output | 8 | Captured input value to the internal logic bus |

## Verification
On every clock the assertions check the following:
- the enable-source rule;
- that no open-drain pin ever drives a 1;
- that the enable-out and live-pin reads mirror the pin state;
- that a direction write lands one edge later;
- that the address latch holds while `ale` stays low.

Only the bench scenarios can show the rest:
- the source selection between register, macrocell and address byte;
- the byte choice of the latch;
- that writes to read-only addresses are ignored;
- that the lower open-drain bits are inert;
- the two input cell modes with their gate and capture-clock sequences.

The bench compares these against its reference model on every cycle.

// File: rtl/mio_pkg.sv
package mio_pkg;

   typedef enum logic [2:0] {
      RA_PINS   = 3'd0,
      RA_DIR    = 3'd1,
      RA_ALT    = 3'd2,
      RA_OD     = 3'd3,
      RA_OEN    = 3'd4,
      RA_CFG    = 3'd5,
      RA_INCELL = 3'd6,
      RA_DOUT   = 3'd7
   } reg_addr_e;

   // configuration register, bit3 down to bit0
   typedef struct packed {
      logic in_reg_mode;   // bit3: input cell register mode
      logic oe_from_pt;    // bit2: enable from product term
      logic addr_hi;       // bit1: latch upper address byte
      logic alt_is_addr;   // bit0: alternate source is address latch
   } cfg_t;

   localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/mio_regs.sv
module mio_regs
   import mio_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int OD_LSB = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] dout_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] alt_q,
   output logic [WIDTH-1:0] od_q,
   output cfg_t             cfg_q
);

   localparam logic [WIDTH-1:0] LOW_ONES = WIDTH'((1 << OD_LSB) - 1);
   localparam logic [WIDTH-1:0] OD_MASK  = ~LOW_ONES;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         dir_q  <= '0;
         alt_q  <= '0;
         od_q   <= '0;
         cfg_q  <= cfg_t'('0);
      end else if (wr_en) begin
         case (wr_addr)
            RA_PINS: dout_q <= wr_data;
            RA_DIR:  dir_q  <= wr_data;
            RA_ALT:  alt_q  <= wr_data;
            RA_OD:   od_q   <= wr_data & OD_MASK;
            RA_CFG:  cfg_q  <= cfg_t'(wr_data[CFG_W-1:0]);
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/mio_addr_latch.sv
module mio_addr_latch #(
   parameter int WIDTH = 8
) (
   input  logic             rst_n,
   input  logic             ale,
   input  logic             hi_sel,
   input  logic [WIDTH-1:0] addr_lo,
   input  logic [WIDTH-1:0] addr_hi,
   output logic [WIDTH-1:0] lat_q
);

   logic [WIDTH-1:0] byte_sel;
   assign byte_sel = hi_sel ? addr_hi : addr_lo;

   always_latch begin
      if (!rst_n)
         lat_q <= '0;
      else if (ale)
         lat_q <= byte_sel;
   end

endmodule

// File: rtl/mio_pin_drv.sv
module mio_pin_drv #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] dout,
   input  logic [WIDTH-1:0] alt,
   input  logic             alt_is_addr,
   input  logic [WIDTH-1:0] mcell,
   input  logic [WIDTH-1:0] addr_lat,
   input  logic [WIDTH-1:0] dir,
   input  logic [WIDTH-1:0] pt_oe,
   input  logic             oe_from_pt,
   input  logic [WIDTH-1:0] od,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic src;
      logic en;
      assign src = alt[i] ? (alt_is_addr ? addr_lat[i] : mcell[i]) : dout[i];
      assign en  = oe_from_pt ? pt_oe[i] : dir[i];
      // open-drain: only ever pull low, release for a one
      assign pad_out[i] = od[i] ? 1'b0 : src;
      assign pad_oe[i]  = od[i] ? (en & ~src) : en;
   end

endmodule

// File: rtl/mio_in_cell.sv
module mio_in_cell #(
   parameter int WIDTH = 8
) (
   input  logic             rst_n,
   input  logic             reg_mode,
   input  logic             gate,
   input  logic             cap_clk,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] cell_q
);

   logic [WIDTH-1:0] lat_q;
   logic [WIDTH-1:0] reg_q;

   always_latch begin
      if (!rst_n)
         lat_q <= '0;
      else if (gate)
         lat_q <= pad_in;
   end

   always_ff @(posedge cap_clk or negedge rst_n) begin
      if (!rst_n)
         reg_q <= '0;
      else
         reg_q <= pad_in;
   end

   assign cell_q = reg_mode ? reg_q : lat_q;

endmodule

// File: rtl/mio_port.sv
module mio_port
   import mio_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int OD_LSB = 4,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        reg_addr,
   input  logic [WIDTH-1:0]  wr_data,
   output logic [WIDTH-1:0]  rd_data,
   input  logic [WIDTH-1:0]  mcell_in,
   input  logic [WIDTH-1:0]  pt_oe_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              ale,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe,
   input  logic              in_gate,
   input  logic              in_cap_clk,
   output logic [WIDTH-1:0]  in_bus
);

   localparam int CFG_PAD = WIDTH - CFG_W;

   if (ADDR_W != 2 * WIDTH) begin : g_bad_addr
      $error("mio_port: ADDR_W must be twice WIDTH");
   end
   if (OD_LSB < 0 || OD_LSB > WIDTH) begin : g_bad_od
      $error("mio_port: OD_LSB out of range");
   end
   if (WIDTH < CFG_W) begin : g_bad_width
      $error("mio_port: WIDTH too small for configuration register");
   end

   logic [WIDTH-1:0] dout_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] alt_q;
   logic [WIDTH-1:0] od_q;
   cfg_t             cfg_q;
   logic [WIDTH-1:0] addr_lat;

   mio_regs #(.WIDTH(WIDTH), .OD_LSB(OD_LSB)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (reg_addr),
      .wr_data (wr_data),
      .dout_q  (dout_q),
      .dir_q   (dir_q),
      .alt_q   (alt_q),
      .od_q    (od_q),
      .cfg_q   (cfg_q)
   );

   mio_addr_latch #(.WIDTH(WIDTH)) u_alat (
      .rst_n   (rst_n),
      .ale     (ale),
      .hi_sel  (cfg_q.addr_hi),
      .addr_lo (addr_in[WIDTH-1:0]),
      .addr_hi (addr_in[ADDR_W-1:WIDTH]),
      .lat_q   (addr_lat)
   );

   mio_pin_drv #(.WIDTH(WIDTH)) u_drv (
      .dout        (dout_q),
      .alt         (alt_q),
      .alt_is_addr (cfg_q.alt_is_addr),
      .mcell       (mcell_in),
      .addr_lat    (addr_lat),
      .dir         (dir_q),
      .pt_oe       (pt_oe_in),
      .oe_from_pt  (cfg_q.oe_from_pt),
      .od          (od_q),
      .pad_out     (pad_out),
      .pad_oe      (pad_oe)
   );

   mio_in_cell #(.WIDTH(WIDTH)) u_incell (
      .rst_n    (rst_n),
      .reg_mode (cfg_q.in_reg_mode),
      .gate     (in_gate),
      .cap_clk  (in_cap_clk),
      .pad_in   (pad_in),
      .cell_q   (in_bus)
   );

   always_comb begin
      case (reg_addr)
         RA_PINS:   rd_data = pad_in;
         RA_DIR:    rd_data = dir_q;
         RA_ALT:    rd_data = alt_q;
         RA_OD:     rd_data = od_q;
         RA_OEN:    rd_data = pad_oe;
         RA_CFG:    rd_data = {{CFG_PAD{1'b0}}, cfg_q};
         RA_INCELL: rd_data = in_bus;
         default:   rd_data = dout_q;
      endcase
   end

endmodule

// File: rtl/mio_port_chk.sv
module mio_port_chk
   import mio_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [2:0]       reg_addr,
   input logic [WIDTH-1:0] wr_data,
   input logic [WIDTH-1:0] rd_data,
   input logic [WIDTH-1:0] pt_oe_in,
   input logic             ale,
   input logic [WIDTH-1:0] pad_in,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] dir_q,
   input logic [WIDTH-1:0] od_q,
   input cfg_t             cfg_q,
   input logic [WIDTH-1:0] addr_lat
);

   p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr == RA_DIR) |=> (dir_q == $past(wr_data)));

   p_oe_from_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q.oe_from_pt |-> ((pad_oe & ~od_q) == (dir_q & ~od_q)));

   p_oe_within_pt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.oe_from_pt |-> ((pad_oe & ~pt_oe_in) == '0));

   p_od_never_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & od_q & pad_out) == '0));

   p_latch_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ale && $past(!ale)) |-> $stable(addr_lat));

   p_pins_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == RA_PINS) |-> (rd_data == pad_in));

   p_oen_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == RA_OEN) |-> (rd_data == pad_oe));

endmodule

bind mio_port mio_port_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .reg_addr (reg_addr),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .pt_oe_in (pt_oe_in),
   .ale      (ale),
   .pad_in   (pad_in),
   .pad_out  (pad_out),
   .pad_oe   (pad_oe),
   .dir_q    (dir_q),
   .od_q     (od_q),
   .cfg_q    (cfg_q),
   .addr_lat (addr_lat)
);

// File: tb/mio_port_tb.sv
module mio_port_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [7:0]  wr_data = 8'h00;
   logic [7:0]  rd_data;
   logic [7:0]  mcell_in = 8'h00;
   logic [7:0]  pt_oe_in = 8'h00;
   logic [15:0] addr_in = 16'h0000;
   logic        ale = 1'b0;
   logic [7:0]  pad_in = 8'h00;
   logic [7:0]  pad_out;
   logic [7:0]  pad_oe;
   logic        in_gate = 1'b0;
   logic        in_cap_clk = 1'b0;
   logic [7:0]  in_bus;

   int checks = 0;
   int failures = 0;
   bit cmp_on = 1'b0;

   // reference model state
   logic [7:0] m_dout = 0, m_dir = 0, m_alt = 0, m_od = 0, m_lat = 0;
   logic [7:0] m_inl = 0, m_inr = 0;
   logic [3:0] m_cfg = 0;

   always #5 clk = ~clk;

   mio_port u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
      .wr_data(wr_data), .rd_data(rd_data), .mcell_in(mcell_in),
      .pt_oe_in(pt_oe_in), .addr_in(addr_in), .ale(ale), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .in_gate(in_gate),
      .in_cap_clk(in_cap_clk), .in_bus(in_bus)
   );

   function automatic logic [7:0] sel_byte();
      return m_cfg[1] ? addr_in[15:8] : addr_in[7:0];
   endfunction

   function automatic logic [15:0] exp_pins();
      logic [7:0] o, e;
      for (int i = 0; i < 8; i++) begin
         logic s, en;
         s  = m_alt[i] ? (m_cfg[0] ? m_lat[i] : mcell_in[i]) : m_dout[i];
         en = m_cfg[2] ? pt_oe_in[i] : m_dir[i];
         if (m_od[i]) begin o[i] = 1'b0; e[i] = en & ~s; end
         else         begin o[i] = s;    e[i] = en;      end
      end
      return {o, e};
   endfunction

   function automatic logic [7:0] exp_in();
      return m_cfg[3] ? m_inr : m_inl;
   endfunction

   function automatic logic [7:0] exp_rd(input logic [2:0] a);
      logic [15:0] p;
      p = exp_pins();
      case (a)
         3'd0: return pad_in;
         3'd1: return m_dir;
         3'd2: return m_alt;
         3'd3: return m_od;
         3'd4: return p[7:0];
         3'd5: return {4'h0, m_cfg};
         3'd6: return exp_in();
         default: return m_dout;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on) begin
         logic [15:0] p;
         p = exp_pins();
         chk("R3 cycle pad_out", pad_out, p[15:8]);
         chk("R4 cycle pad_oe", pad_oe, p[7:0]);
         chk("R7 cycle rd_data", rd_data, exp_rd(reg_addr));
         chk("R9 cycle in_bus", in_bus, exp_in());
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); #1;
      wr_en = 1'b1; reg_addr = a; wr_data = d;
      @(posedge clk); #1;
      case (a)
         3'd0: m_dout = d;
         3'd1: m_dir  = d;
         3'd2: m_alt  = d;
         3'd3: m_od   = d & 8'hF0;
         3'd5: m_cfg  = d[3:0];
         default: ;
      endcase
      if (ale) m_lat = sel_byte();
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk); #1;
      reg_addr = a; #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic set_addr(input logic [15:0] v);
      @(negedge clk); #1;
      addr_in = v;
      if (ale) m_lat = sel_byte();
   endtask

   task automatic set_ale(input logic v);
      @(negedge clk); #1;
      ale = v;
      if (v) m_lat = sel_byte();
   endtask

   task automatic set_pads(input logic [7:0] v);
      @(negedge clk); #1;
      pad_in = v;
      if (in_gate) m_inl = v;
   endtask

   task automatic set_gate(input logic g);
      @(negedge clk); #1;
      in_gate = g;
      if (g) m_inl = pad_in;
   endtask

   task automatic cap_pulse();
      @(negedge clk); #1;
      in_cap_clk = 1'b1; m_inr = pad_in;
      #2 in_cap_clk = 1'b0;
   endtask

   task automatic run_all();
      repeat (3) @(posedge clk);
      @(negedge clk); #1 rst_n = 1'b1;
      // R1 reset state
      #1 chk("R1 pad_oe after reset", pad_oe, 8'h00);
      for (int a = 1; a < 8; a++) rd_chk(3'(a), 8'h00, "R1 register read after reset");
      cmp_on = 1'b1;

      // R2 writes and ignored addresses
      wr(3'd0, 8'hA5);
      wr(3'd1, 8'hFF);
      rd_chk(3'd7, 8'hA5, "R2 data register write");
      rd_chk(3'd1, 8'hFF, "R2 direction write");
      #1 chk("R3 register source on pins", pad_out, 8'hA5);
      wr(3'd4, 8'h3C);
      wr(3'd6, 8'h3C);
      wr(3'd7, 8'h00);
      rd_chk(3'd7, 8'hA5, "R2 write to 7 ignored");
      rd_chk(3'd1, 8'hFF, "R2 write to 4 and 6 ignored");
      rd_chk(3'd5, 8'h00, "R2 config untouched");

      // R3 macrocell source on upper pins
      mcell_in = 8'h0F;
      wr(3'd2, 8'hF0);
      #1 chk("R3 macrocell source", pad_out, 8'h05);

      // R6 address latch, low byte then high byte
      set_addr(16'h12C4);
      set_ale(1'b1);
      wr(3'd5, 8'h01);
      #1 chk("R3 latched address source", pad_out, 8'hC5);
      set_ale(1'b0);
      set_addr(16'h3355);
      #1 chk("R6 latch holds while ale low", pad_out, 8'hC5);
      wr(3'd5, 8'h03);
      #1 chk("R6 byte select change held", pad_out, 8'hC5);
      set_ale(1'b1);
      #1 chk("R6 high byte when transparent", pad_out, 8'h35);
      set_ale(1'b0);

      // R4 product-term enable
      pt_oe_in = 8'h3C;
      wr(3'd5, 8'h04);
      #1 chk("R4 enable from product term", pad_oe, 8'h3C);
      wr(3'd1, 8'h00);
      #1 chk("R4 direction ignored in pt mode", pad_oe, 8'h3C);

      // R5 open-drain on upper bits
      wr(3'd5, 8'h00);
      wr(3'd1, 8'hFF);
      wr(3'd2, 8'h00);
      wr(3'd0, 8'h50);
      wr(3'd3, 8'hFF);
      rd_chk(3'd3, 8'hF0, "R5 lower open-drain bits read 0");
      #1 chk("R5 open-drain pad_oe", pad_oe, 8'hAF);
      #1 chk("R5 open-drain pad_out", pad_out, 8'h00);
      rd_chk(3'd4, 8'hAF, "R8 enable-out with release");
      wr(3'd0, 8'h51);
      #1 chk("R5 lower pin stays push-pull", pad_out, 8'h01);
      rd_chk(3'd4, 8'hAF, "R8 enable-out push-pull");

      // R9 input cell latch mode
      set_pads(8'h99);
      set_gate(1'b1);
      #1 chk("R9 latch transparent", in_bus, 8'h99);
      set_pads(8'h66);
      #1 chk("R9 latch follows", in_bus, 8'h66);
      set_gate(1'b0);
      set_pads(8'h11);
      rd_chk(3'd6, 8'h66, "R9 latch holds");
      rd_chk(3'd0, 8'h11, "R7 live pin read");

      // R10 input cell register mode
      wr(3'd5, 8'h08);
      #1 chk("R10 register empty", in_bus, 8'h00);
      cap_pulse();
      #1 chk("R10 capture on edge", in_bus, 8'h11);
      set_pads(8'h22);
      set_gate(1'b1);
      #1 chk("R10 gate has no effect", in_bus, 8'h11);
      set_gate(1'b0);
      cap_pulse();
      rd_chk(3'd6, 8'h22, "R10 second capture");
      rd_chk(3'd5, 8'h08, "R7 config read");
      repeat (3) @(posedge clk);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
         end
      join_any
      disable fork;
      cmp_on = 1'b0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule